// File: doc/BRIEF.md
# Seconds-Tick Calendar Counter with Field-Masked Alarm

This block keeps time of day and a running day number for a chip that already produces a one-second pulse. Seconds, minutes and hours are held as packed BCD bytes, so software can display them without conversion. Days are one binary counter, split across two byte registers, that software maps to a calendar date by itself. An alarm compares minute, hour and day number against the count. Each of the three fields can be switched on or off on its own, and a match raises a sticky flag and, if enabled, the interrupt line.

All access goes through a byte-wide register file on one address bus, with writes and combinational reads. A counter update takes one clock cycle and is visible as a busy bit. A host write that lands in that cycle is held for one cycle and then applied, so no write is lost to a tick collision.

Top module: `daycal_top`

## Requirements
- R1: After reset every register reads 0x00, so the counter is stopped, all alarm enables are off, the flag is clear and `irq` is low.
- R2: On each `secTick` cycle with the run bit set, seconds advance in packed BCD from 0x00 to 0x59 and wrap to 0x00. Minutes advance when seconds wrap, with the same range. Hours (0x00 to 0x23) advance when minutes wrap. Registers: seconds 0x15, minutes 0x16, hours 0x17.
- R3: The day number is binary. It advances when hours wrap from 0x23 to 0x00, carries from the low byte (0x18) into the high byte (0x19, bits 6:0), and wraps from 0x7FFF to 0.
- R4: A write to any time or alarm register loads the byte given. Reads return the stored values. Reads of unmapped addresses return 0x00.
- R5: The control byte at 0x14 has these bits: 7 busy (read only), 5 day-alarm enable, 4 hour-alarm enable, 3 minute-alarm enable, 2 alarm flag, 1 interrupt enable, 0 run. Bit 6 reads 0.
- R6: The alarm registers are minute 0x1A, hour 0x1B, day low 0x1C and day high 0x1D. The flag is set on the tick that takes seconds to 0x00 when every enabled field equals the newly reached count.
- R7: With no alarm field enabled the flag is never set. A disabled field does not take part in the match.
- R8: Writing the control byte with bit 2 = 1 clears the flag. Writing bit 2 = 0 leaves the flag as it is.
- R9: `irq` is high exactly when the alarm flag and the interrupt enable are both 1.
- R10: Busy reads 1 in any cycle where `secTick` is high and run is 1. A write in such a cycle takes effect one clock later, after the tick update.
- R11: While run is 0, `secTick` has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle pulse once per second |
| addr | input | 8 | Register address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Combinational read of the addressed register |
| irq | output | 1 | Alarm interrupt |

## Verification
The bench builds the block with the default 15-bit day counter, which is the width the address map describes. Day-number wrap and the low-to-high byte carry stay within a few ticks because the time registers can be preloaded, so 23:59:59 on day 0x7FFF is one host write sequence away rather than 32768 days. The one-cycle busy window and the held write are driven on purpose in the same cycle as a tick.

// File: rtl/daycal_pkg.sv
package daycal_pkg;
  localparam int REG_AW = 8;
  localparam int BYTE_W = 8;

  localparam logic [REG_AW-1:0] ADR_CTRL   = 8'h14;
  localparam logic [REG_AW-1:0] ADR_SEC    = 8'h15;
  localparam logic [REG_AW-1:0] ADR_MIN    = 8'h16;
  localparam logic [REG_AW-1:0] ADR_HOUR   = 8'h17;
  localparam logic [REG_AW-1:0] ADR_DAYLO  = 8'h18;
  localparam logic [REG_AW-1:0] ADR_DAYHI  = 8'h19;
  localparam logic [REG_AW-1:0] ADR_AMIN   = 8'h1A;
  localparam logic [REG_AW-1:0] ADR_AHOUR  = 8'h1B;
  localparam logic [REG_AW-1:0] ADR_ADAYLO = 8'h1C;
  localparam logic [REG_AW-1:0] ADR_ADAYHI = 8'h1D;

  localparam int CB_BUSY  = 7;
  localparam int CB_DAYEN = 5;
  localparam int CB_HREN  = 4;
  localparam int CB_MINEN = 3;
  localparam int CB_FLAG  = 2;
  localparam int CB_IE    = 1;
  localparam int CB_RUN   = 0;

  // strobes from control to datapath: tick and write never together
  typedef struct packed {
    logic              tick;
    logic              wr;
    logic [REG_AW-1:0] addr;
    logic [BYTE_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/daycal_ctrl.sv
module daycal_ctrl
  import daycal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic              runEn,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output cmd_t              cmd,
  output logic              busy
);
  logic              pendValid;
  logic [REG_AW-1:0] pendAddr;
  logic [BYTE_W-1:0] pendData;
  logic              capture;

  assign busy    = secTick & runEn;
  assign capture = wrEn & (busy | pendValid);

  always_comb begin
    cmd.tick = busy;
    cmd.wr   = !busy && (pendValid || wrEn);
    cmd.addr = pendValid ? pendAddr : addr;
    cmd.data = pendValid ? pendData : wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendData  <= '0;
    end else if (capture) begin
      pendValid <= 1'b1;
      pendAddr  <= addr;
      pendData  <= wrData;
    end else if (pendValid && !busy) begin
      pendValid <= 1'b0;
    end
  end

  // R10
  held_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && wrEn |=> pendValid && pendAddr == $past(addr) && pendData == $past(wrData));

  // R10
  pend_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    pendValid && !busy && !wrEn |=> !pendValid);
endmodule

// File: rtl/daycal_datapath.sv
module daycal_datapath
  import daycal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmd_t              cmd,
  input  logic              busy,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              runEn,
  output logic              irq
);
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] secR, minR, hourR, aMinR, aHourR;
  logic [DAY_W-1:0]  dayR, aDayR;
  logic              dayEn, hrEn, minEn, flag, ie;
  logic [BYTE_W-1:0] secNxt, minNxt, hourNxt;
  logic [DAY_W-1:0]  dayNxt;
  logic              secWrap, minWrap, hourWrap, almHit;
  logic [WIDE_W-1:0] dayWide, aDayWide;

  function automatic logic [BYTE_W-1:0] bcdInc(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign dayWide  = WIDE_W'(dayR);
  assign aDayWide = WIDE_W'(aDayR);

  always_comb begin
    secWrap  = secR == 8'h59;
    minWrap  = minR == 8'h59;
    hourWrap = hourR == 8'h23;
    secNxt   = secWrap ? 8'h00 : bcdInc(secR);
    minNxt   = secWrap ? (minWrap ? 8'h00 : bcdInc(minR)) : minR;
    hourNxt  = (secWrap && minWrap) ? (hourWrap ? 8'h00 : bcdInc(hourR)) : hourR;
    dayNxt   = (secWrap && minWrap && hourWrap) ? dayR + 1'b1 : dayR;
    almHit   = secWrap && (minEn || hrEn || dayEn)
             && (!minEn || minNxt == aMinR)
             && (!hrEn  || hourNxt == aHourR)
             && (!dayEn || dayNxt == aDayR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secR <= '0; minR <= '0; hourR <= '0; dayR <= '0;
      aMinR <= '0; aHourR <= '0; aDayR <= '0;
      dayEn <= 1'b0; hrEn <= 1'b0; minEn <= 1'b0;
      flag <= 1'b0; ie <= 1'b0; runEn <= 1'b0;
    end else if (cmd.tick) begin
      secR  <= secNxt;
      minR  <= minNxt;
      hourR <= hourNxt;
      dayR  <= dayNxt;
      if (almHit) flag <= 1'b1;
    end else if (cmd.wr) begin
      unique case (cmd.addr)
        ADR_CTRL: begin
          dayEn <= cmd.data[CB_DAYEN];
          hrEn  <= cmd.data[CB_HREN];
          minEn <= cmd.data[CB_MINEN];
          ie    <= cmd.data[CB_IE];
          runEn <= cmd.data[CB_RUN];
          if (cmd.data[CB_FLAG]) flag <= 1'b0;
        end
        ADR_SEC:    secR   <= cmd.data;
        ADR_MIN:    minR   <= cmd.data;
        ADR_HOUR:   hourR  <= cmd.data;
        ADR_DAYLO:  dayR   <= DAY_W'({dayWide[WIDE_W-1:BYTE_W], cmd.data});
        ADR_DAYHI:  dayR   <= DAY_W'({cmd.data, dayWide[BYTE_W-1:0]});
        ADR_AMIN:   aMinR  <= cmd.data;
        ADR_AHOUR:  aHourR <= cmd.data;
        ADR_ADAYLO: aDayR  <= DAY_W'({aDayWide[WIDE_W-1:BYTE_W], cmd.data});
        ADR_ADAYHI: aDayR  <= DAY_W'({cmd.data, aDayWide[BYTE_W-1:0]});
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rdAddr)
      ADR_CTRL:   rdData = {busy, 1'b0, dayEn, hrEn, minEn, flag, ie, runEn};
      ADR_SEC:    rdData = secR;
      ADR_MIN:    rdData = minR;
      ADR_HOUR:   rdData = hourR;
      ADR_DAYLO:  rdData = dayWide[BYTE_W-1:0];
      ADR_DAYHI:  rdData = dayWide[WIDE_W-1:BYTE_W];
      ADR_AMIN:   rdData = aMinR;
      ADR_AHOUR:  rdData = aHourR;
      ADR_ADAYLO: rdData = aDayWide[BYTE_W-1:0];
      ADR_ADAYHI: rdData = aDayWide[WIDE_W-1:BYTE_W];
      default:    rdData = '0;
    endcase
  end

  assign irq = flag & ie;

  // R2
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.tick && secR == 8'h59 |=> secR == 8'h00);

  // R3
  day_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.tick && secR == 8'h59 && minR == 8'h59 && hourR == 8'h23
    && dayR == {DAY_W{1'b1}} |=> dayR == '0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.tick && !cmd.wr |=> $stable(secR) && $stable(minR) && $stable(hourR) && $stable(dayR));

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(cmd.tick) && $past(secR) == 8'h59);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wr && cmd.addr == ADR_CTRL && cmd.data[CB_FLAG] |=> !flag);
endmodule

// File: rtl/daycal_top.sv
module daycal_top
  import daycal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secTick,
  input  logic [REG_AW-1:0] addr,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              irq
);
  cmd_t cmd;
  logic busy;
  logic runEn;

  daycal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .secTick(secTick), .runEn(runEn),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .cmd(cmd), .busy(busy)
  );

  daycal_datapath #(.DAY_W(DAY_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busy(busy), .rdAddr(addr),
    .rdData(rdData), .runEn(runEn), .irq(irq)
  );
endmodule

// File: tb/daycal_top_test.sv
module daycal_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int SAMPLE_DLY = 3;
  localparam int DAY_W = 15;
  localparam int DAY_MASK = (1 << DAY_W) - 1;

  localparam logic [7:0] A_CTRL = 8'h14, A_SEC = 8'h15, A_MIN = 8'h16, A_HOUR = 8'h17;
  localparam logic [7:0] A_DLO = 8'h18, A_DHI = 8'h19, A_AMIN = 8'h1A, A_AHOUR = 8'h1B;
  localparam logic [7:0] A_ADLO = 8'h1C, A_ADHI = 8'h1D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic secTick = 1'b0;
  logic [7:0] addr = 8'h00;
  logic wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic irq;

  int checks = 0;
  int failures = 0;
  bit checkOn = 1'b0;

  daycal_top #(.DAY_W(DAY_W)) uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .addr(addr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // ---------------- reference model (binary integers) ----------------
  int mSec = 0, mMin = 0, mHour = 0, mDay = 0, mADay = 0;
  logic [7:0] mAMin = 0, mAHour = 0;
  bit mDayEn = 0, mHrEn = 0, mMinEn = 0, mFlag = 0, mIe = 0, mRun = 0;
  logic [15:0] held[$];

  function automatic int bcd2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic modelTick();
    mSec = mSec + 1;
    if (mSec == 60) begin
      mSec = 0;
      mMin = mMin + 1;
      if (mMin == 60) begin
        mMin = 0;
        mHour = mHour + 1;
        if (mHour == 24) begin
          mHour = 0;
          mDay = (mDay + 1) & DAY_MASK;
        end
      end
    end
    if (mSec == 0 && (mDayEn || mHrEn || mMinEn)
        && (!mMinEn || i2bcd(mMin) == mAMin)
        && (!mHrEn || i2bcd(mHour) == mAHour)
        && (!mDayEn || mDay == mADay))
      mFlag = 1;
  endtask

  task automatic modelWrite(input logic [7:0] a, input logic [7:0] d);
    case (a)
      A_CTRL: begin
        mDayEn = d[5]; mHrEn = d[4]; mMinEn = d[3]; mIe = d[1]; mRun = d[0];
        if (d[2]) mFlag = 0;
      end
      A_SEC:   mSec = bcd2i(d);
      A_MIN:   mMin = bcd2i(d);
      A_HOUR:  mHour = bcd2i(d);
      A_DLO:   mDay = (mDay & 32'hFF00) | int'(d);
      A_DHI:   mDay = ((int'(d) << 8) | (mDay & 32'hFF)) & DAY_MASK;
      A_AMIN:  mAMin = d;
      A_AHOUR: mAHour = d;
      A_ADLO:  mADay = (mADay & 32'hFF00) | int'(d);
      A_ADHI:  mADay = ((int'(d) << 8) | (mADay & 32'hFF)) & DAY_MASK;
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSec = 0; mMin = 0; mHour = 0; mDay = 0; mADay = 0; mAMin = 0; mAHour = 0;
      mDayEn = 0; mHrEn = 0; mMinEn = 0; mFlag = 0; mIe = 0; mRun = 0;
      held.delete();
    end else if (secTick && mRun) begin
      modelTick();
      if (wrEn) held.push_back({addr, wrData});
    end else if (held.size() > 0) begin
      logic [15:0] w;
      w = held.pop_front();
      modelWrite(w[15:8], w[7:0]);
      if (wrEn) held.push_back({addr, wrData});
    end else if (wrEn) begin
      modelWrite(addr, wrData);
    end
  end

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    case (a)
      A_CTRL:  return {secTick && mRun, 1'b0, mDayEn, mHrEn, mMinEn, mFlag, mIe, mRun};
      A_SEC:   return i2bcd(mSec);
      A_MIN:   return i2bcd(mMin);
      A_HOUR:  return i2bcd(mHour);
      A_DLO:   return 8'(mDay);
      A_DHI:   return 8'(mDay >> 8);
      A_AMIN:  return mAMin;
      A_AHOUR: return mAHour;
      A_ADLO:  return 8'(mADay);
      A_ADHI:  return 8'(mADay >> 8);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string reqOf(input logic [7:0] a);
    if (a == A_CTRL) return "R5";
    if (a == A_SEC || a == A_MIN || a == A_HOUR) return "R2";
    if (a == A_DLO || a == A_DHI) return "R3";
    if (a >= A_AMIN && a <= A_ADHI) return "R6";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the edge
  always @(posedge clk) begin
    #(SAMPLE_DLY);
    if (checkOn) begin
      check(rdData == modelRead(addr), reqOf(addr), int'(rdData), int'(modelRead(addr)));
      check(irq == (mFlag && mIe), "R9", int'(irq), int'(mFlag && mIe));
    end
  end

  // ---------------- stimulus ----------------
  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1; secTick = 1'b0;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      secTick = 1'b1;
      @(negedge clk);
      secTick = 1'b0;
    end
  endtask

  task automatic expectRead(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; wrEn = 1'b0; secTick = 1'b0;
    @(posedge clk);
    #(SAMPLE_DLY);
    check(rdData == exp, tag, int'(rdData), int'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkOn = 1'b1;

    // R1 reset state
    expectRead(A_CTRL, 8'h00, "R1");
    expectRead(A_SEC, 8'h00, "R1");
    expectRead(A_ADHI, 8'h00, "R1");
    check(irq == 1'b0, "R1", int'(irq), 0);

    // R11 ticks ignored while stopped
    tick(3);
    expectRead(A_SEC, 8'h00, "R11");

    // R2 counting
    writeReg(A_CTRL, 8'h01);
    tick(5);
    expectRead(A_SEC, 8'h05, "R2");

    // R2 BCD carry into hours, day unchanged
    writeReg(A_HOUR, 8'h09); writeReg(A_MIN, 8'h59); writeReg(A_SEC, 8'h59);
    tick(1);
    expectRead(A_HOUR, 8'h10, "R2");
    expectRead(A_MIN, 8'h00, "R2");
    expectRead(A_DLO, 8'h00, "R3");

    // R3 low-to-high day carry
    writeReg(A_DLO, 8'hFF); writeReg(A_DHI, 8'h00);
    writeReg(A_HOUR, 8'h23); writeReg(A_MIN, 8'h59); writeReg(A_SEC, 8'h59);
    tick(1);
    expectRead(A_DLO, 8'h00, "R3");
    expectRead(A_DHI, 8'h01, "R3");

    // R3 full wrap from 0x7FFF
    writeReg(A_SEC, 8'h58); writeReg(A_MIN, 8'h59); writeReg(A_HOUR, 8'h23);
    writeReg(A_DLO, 8'hFF); writeReg(A_DHI, 8'h7F);
    expectRead(A_DHI, 8'h7F, "R4");
    tick(1);
    expectRead(A_SEC, 8'h59, "R2");
    tick(1);
    expectRead(A_SEC, 8'h00, "R2");
    expectRead(A_HOUR, 8'h00, "R2");
    expectRead(A_DLO, 8'h00, "R3");
    expectRead(A_DHI, 8'h00, "R3");

    // R4 direct load and unmapped reads
    writeReg(A_MIN, 8'h42);
    expectRead(A_MIN, 8'h42, "R4");
    expectRead(8'h00, 8'h00, "R4");
    expectRead(8'h1E, 8'h00, "R4");

    // R6 full alarm match
    writeReg(A_DLO, 8'h23); writeReg(A_DHI, 8'h01);
    writeReg(A_HOUR, 8'h05); writeReg(A_MIN, 8'h09); writeReg(A_SEC, 8'h58);
    writeReg(A_AMIN, 8'h10); writeReg(A_AHOUR, 8'h05);
    writeReg(A_ADLO, 8'h23); writeReg(A_ADHI, 8'h01);
    writeReg(A_CTRL, 8'h3B);
    tick(1);
    expectRead(A_CTRL, 8'h3B, "R6");
    tick(1);
    expectRead(A_CTRL, 8'h3F, "R6");
    check(irq == 1'b1, "R9", int'(irq), 1);

    // R8 write-one-to-clear
    writeReg(A_CTRL, 8'h3B);
    expectRead(A_CTRL, 8'h3F, "R8");
    writeReg(A_CTRL, 8'h3F);
    expectRead(A_CTRL, 8'h3B, "R8");
    check(irq == 1'b0, "R8", int'(irq), 0);

    // R7 enabled minute mismatches
    writeReg(A_CTRL, 8'h0B); writeReg(A_MIN, 8'h10); writeReg(A_SEC, 8'h59);
    tick(1);
    expectRead(A_CTRL, 8'h0B, "R7");

    // R7 nothing enabled although minute would match
    writeReg(A_CTRL, 8'h03); writeReg(A_AMIN, 8'h12); writeReg(A_SEC, 8'h59);
    tick(1);
    expectRead(A_CTRL, 8'h03, "R7");

    // R7 hour disabled and mismatched, minute enabled and matching; R9 ie off
    writeReg(A_AHOUR, 8'h07); writeReg(A_AMIN, 8'h13);
    writeReg(A_CTRL, 8'h09); writeReg(A_SEC, 8'h59);
    tick(1);
    expectRead(A_CTRL, 8'h0D, "R7");
    check(irq == 1'b0, "R9", int'(irq), 0);
    writeReg(A_CTRL, 8'h0B);
    expectRead(A_CTRL, 8'h0F, "R9");
    check(irq == 1'b1, "R9", int'(irq), 1);
    writeReg(A_CTRL, 8'h07);
    expectRead(A_CTRL, 8'h03, "R8");

    // R10 busy bit and a write held across a tick
    writeReg(A_SEC, 8'h10);
    @(negedge clk);
    addr = A_CTRL; secTick = 1'b1; wrEn = 1'b0;
    #1;
    check(rdData[7] == 1'b1, "R10", int'(rdData[7]), 1);
    @(negedge clk);
    addr = A_SEC; wrData = 8'h30; wrEn = 1'b1; secTick = 1'b1;
    @(posedge clk);
    #(SAMPLE_DLY);
    check(rdData == 8'h12, "R10", int'(rdData), 8'h12);
    @(negedge clk);
    wrEn = 1'b0; secTick = 1'b0;
    @(posedge clk);
    #(SAMPLE_DLY);
    check(rdData == 8'h30, "R10", int'(rdData), 8'h30);

    // R11 busy stays low while stopped
    writeReg(A_CTRL, 8'h00);
    @(negedge clk);
    addr = A_CTRL; secTick = 1'b1;
    #1;
    check(rdData[7] == 1'b0, "R11", int'(rdData[7]), 0);
    @(negedge clk);
    secTick = 1'b0;
    expectRead(A_SEC, 8'h30, "R11");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule